// File: doc/BRIEF.md
# External Wakeup and Interrupt Controller

This block watches a bank of external pad inputs and one non-maskable interrupt input. Each input is brought into the clock domain by a two-flop synchronizer. A rising or falling transition is then detected, and for each pad a per-edge enable decides whether that transition counts. A transition that counts latches a sticky event flag for its channel. Software clears a flag by writing 1 to its bit.

Two independent enable masks turn the pad flags into requests. One mask feeds a combined interrupt request and the other feeds a system wakeup request. The non-maskable channel has its own event flag, an overrun flag, a wakeup enable, a destination select and a lock bit. Once the lock bit is set, the channel's configuration is frozen until reset. Per-pad pull-up and filter enables are held in registers and driven straight out to the pad ring.

Software reaches the block over a plain word-wide register bus made of an address, a write strobe, write data and read data. Read data is registered and appears one clock after the address.

Top module: `ext_wake_ctrl`

## Requirements
- R1: After reset every register reads zero and irq_o, wake_o, nmi_o, pullup_en_o, filter_en_o and nmi_filter_en_o are all zero.
- R2: Byte offsets 0x18 (interrupt enable), 0x1C (wakeup enable), 0x28 (rising enable), 0x2C (falling enable), 0x30 (filter enable) and 0x34 (pull-up enable) read back the last value written. pullup_en_o follows 0x34 and filter_en_o follows 0x30. Read data appears one clock after the address is presented. Unmapped offsets inside the 0x38-byte window read zero.
- R3: Pad flag bit n at offset 0x14 is set after pad n rises while rising-enable bit n is 1, or after pad n falls while falling-enable bit n is 1. It becomes visible within 4 clocks of the pad change. A transition whose edge type is disabled sets nothing.
- R4: Writing 1 to a status flag bit clears it, and writing 0 leaves it unchanged. If a new event and a clearing write arrive in the same cycle, the flag stays set.
- R5: irq_o is 1 exactly when some pad flag bit and the matching bit at 0x18 are both 1. It lags the flags by one clock.
- R6: wake_o is 1 when some pad flag bit and the matching bit at 0x1C are both 1. It is also 1 when the NMI wakeup enable is 1 and either the NMI event flag or the NMI overrun flag is set.
- R7: NMI status at 0x00 holds the NMI event flag in bit 31 and the overrun flag in bit 30, and bits 29:0 read zero. The event flag sets on an enabled NMI edge. The overrun flag sets when an enabled NMI edge arrives while the event flag is already set.
- R8: NMI configuration at 0x08 holds filter enable in bit 24, falling enable in bit 25, rising enable in bit 26, wakeup enable in bit 28, destination select in bits 30:29 and lock in bit 31. Bits 23:0 and bit 27 read zero. nmi_filter_en_o follows bit 24.
- R9: nmi_o is 1 while the NMI event flag is set and the destination select is 00. Any other select value gives no nmi_o.
- R10: Once the lock bit has been written as 1, later writes to 0x08 leave it unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NPAD | Asynchronous pad inputs |
| nmi_in | input | 1 | Asynchronous non-maskable interrupt input |
| bus_addr | input | AW | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | System wakeup request |
| nmi_o | output | 1 | Non-maskable interrupt request |
| pullup_en_o | output | NPAD | Per-pad pull-up enables |
| filter_en_o | output | NPAD | Per-pad filter enables |
| nmi_filter_en_o | output | 1 | NMI pad filter enable |

## Verification
On every cycle the assertions check several properties. A set pad flag survives any cycle that carries no clearing write. The locked configuration never moves. An overrun only rises while the event flag is held. irq_o and nmi_o are only raised when their enabled sources were present one clock earlier. The reserved status bits never read nonzero. Some behaviour can only be shown by the bench's scenarios: which edge types set which flags under random enable masks, the new-event-wins collision with a clearing write, the readback of each offset, and the exact request levels.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
  localparam int unsigned REG_W = 32;
  // word indices (byte offset / 4)
  localparam int unsigned IX_NSTAT = 0;
  localparam int unsigned IX_NCFG  = 2;
  localparam int unsigned IX_PFLAG = 5;
  localparam int unsigned IX_IEN   = 6;
  localparam int unsigned IX_WEN   = 7;
  localparam int unsigned IX_REN   = 10;
  localparam int unsigned IX_FEN   = 11;
  localparam int unsigned IX_FILT  = 12;
  localparam int unsigned IX_PULL  = 13;
  // NMI field positions
  localparam int unsigned B_NFLAG = 31;
  localparam int unsigned B_NOVF  = 30;
  localparam int unsigned B_LOCK  = 31;
  localparam int unsigned B_DSS_H = 30;
  localparam int unsigned B_DSS_L = 29;
  localparam int unsigned B_NWEN  = 28;
  localparam int unsigned B_NREN  = 26;
  localparam int unsigned B_NFEN  = 25;
  localparam int unsigned B_NFILT = 24;

  typedef struct packed {
    logic       lock;
    logic [1:0] dss;
    logic       wen;
    logic       ren;
    logic       fen;
    logic       filt;
  } nmi_cfg_t;
endpackage

// File: rtl/ewc_sync.sv
module ewc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= '0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ewc_edge.sv
module ewc_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_i;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign ev_o[i] = (sync_i[i] & ~prev_q[i] & rise_en_i[i]) |
                       (~sync_i[i] & prev_q[i] & fall_en_i[i]);
    end
  endgenerate
endmodule

// File: rtl/ewc_nmi_chan.sv
module ewc_nmi_chan
  import ewc_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     nmi_in,
  input  logic     stat_we_i,
  input  logic     clr_flag_i,
  input  logic     clr_ovf_i,
  input  logic     cfg_we_i,
  input  nmi_cfg_t cfg_wr_i,
  output nmi_cfg_t cfg_o,
  output logic     flag_o,
  output logic     ovf_o,
  output logic     req_o,
  output logic     wake_o
);
  logic     nmi_s;
  logic     ev;
  logic     flag_q, ovf_q;
  nmi_cfg_t cfg_q;

  ewc_sync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(nmi_in), .sync_o(nmi_s)
  );

  ewc_edge #(.W(1)) u_edge (
    .clk(clk), .rst(rst), .sync_i(nmi_s),
    .rise_en_i(cfg_q.ren), .fall_en_i(cfg_q.fen), .ev_o(ev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we_i && !cfg_q.lock) begin
      cfg_q <= cfg_wr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      flag_q <= ev | (flag_q & ~(stat_we_i & clr_flag_i));
      ovf_q  <= (ev & flag_q) | (ovf_q & ~(stat_we_i & clr_ovf_i));
    end
  end

  assign cfg_o  = cfg_q;
  assign flag_o = flag_q;
  assign ovf_o  = ovf_q;
  assign req_o  = flag_q & (cfg_q.dss == 2'b00);
  assign wake_o = cfg_q.wen & (flag_q | ovf_q);

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_q.lock |=> $stable(cfg_q)); // R10
  AST_OVF_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> flag_q); // R7
endmodule

// File: rtl/ext_wake_ctrl.sv
module ext_wake_ctrl
  import ewc_pkg::*;
#(
  parameter int unsigned NPAD   = 32,
  parameter int unsigned AW     = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPAD-1:0]  pad_in,
  input  logic             nmi_in,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             wake_o,
  output logic             nmi_o,
  output logic [NPAD-1:0]  pullup_en_o,
  output logic [NPAD-1:0]  filter_en_o,
  output logic             nmi_filter_en_o
);
  localparam int unsigned IXW = AW - 2;

  logic [IXW-1:0] widx;
  logic           unused_addr;
  assign widx        = bus_addr[AW-1:2];
  assign unused_addr = ^bus_addr[1:0];

  function automatic logic hit(input logic [IXW-1:0] ix, input int unsigned which);
    return ix == IXW'(which);
  endfunction

  function automatic logic [REG_W-1:0] widen(input logic [NPAD-1:0] v);
    logic [REG_W-1:0] r;
    r = '0;
    r[NPAD-1:0] = v;
    return r;
  endfunction

  // pad configuration registers
  logic [NPAD-1:0] ien_q, wen_q, ren_q, fen_q, filt_q, pull_q;
  logic [NPAD-1:0] pflag_q, pad_s, pad_ev, pclr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      wen_q  <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      filt_q <= '0;
      pull_q <= '0;
    end else if (bus_we) begin
      if (hit(widx, IX_IEN))  ien_q  <= bus_wdata[NPAD-1:0];
      if (hit(widx, IX_WEN))  wen_q  <= bus_wdata[NPAD-1:0];
      if (hit(widx, IX_REN))  ren_q  <= bus_wdata[NPAD-1:0];
      if (hit(widx, IX_FEN))  fen_q  <= bus_wdata[NPAD-1:0];
      if (hit(widx, IX_FILT)) filt_q <= bus_wdata[NPAD-1:0];
      if (hit(widx, IX_PULL)) pull_q <= bus_wdata[NPAD-1:0];
    end
  end

  ewc_sync #(.W(NPAD), .STAGES(STAGES)) u_pad_sync (
    .clk(clk), .rst(rst), .async_i(pad_in), .sync_o(pad_s)
  );

  ewc_edge #(.W(NPAD)) u_pad_edge (
    .clk(clk), .rst(rst), .sync_i(pad_s),
    .rise_en_i(ren_q), .fall_en_i(fen_q), .ev_o(pad_ev)
  );

  assign pclr = (bus_we && hit(widx, IX_PFLAG)) ? bus_wdata[NPAD-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) pflag_q <= '0;
    else     pflag_q <= pad_ev | (pflag_q & ~pclr);
  end

  // NMI channel
  nmi_cfg_t ncfg_wr, ncfg;
  logic     nflag, novf, nreq, nwake;

  assign ncfg_wr.lock = bus_wdata[B_LOCK];
  assign ncfg_wr.dss  = bus_wdata[B_DSS_H:B_DSS_L];
  assign ncfg_wr.wen  = bus_wdata[B_NWEN];
  assign ncfg_wr.ren  = bus_wdata[B_NREN];
  assign ncfg_wr.fen  = bus_wdata[B_NFEN];
  assign ncfg_wr.filt = bus_wdata[B_NFILT];

  ewc_nmi_chan #(.STAGES(STAGES)) u_nmi (
    .clk(clk), .rst(rst), .nmi_in(nmi_in),
    .stat_we_i(bus_we && hit(widx, IX_NSTAT)),
    .clr_flag_i(bus_wdata[B_NFLAG]), .clr_ovf_i(bus_wdata[B_NOVF]),
    .cfg_we_i(bus_we && hit(widx, IX_NCFG)), .cfg_wr_i(ncfg_wr),
    .cfg_o(ncfg), .flag_o(nflag), .ovf_o(novf), .req_o(nreq), .wake_o(nwake)
  );

  // read path
  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit(widx, IX_NSTAT)) begin
      rd_mux[B_NFLAG] = nflag;
      rd_mux[B_NOVF]  = novf;
    end
    if (hit(widx, IX_NCFG)) begin
      rd_mux[B_LOCK]          = ncfg.lock;
      rd_mux[B_DSS_H:B_DSS_L] = ncfg.dss;
      rd_mux[B_NWEN]          = ncfg.wen;
      rd_mux[B_NREN]          = ncfg.ren;
      rd_mux[B_NFEN]          = ncfg.fen;
      rd_mux[B_NFILT]         = ncfg.filt;
    end
    if (hit(widx, IX_PFLAG)) rd_mux = widen(pflag_q);
    if (hit(widx, IX_IEN))   rd_mux = widen(ien_q);
    if (hit(widx, IX_WEN))   rd_mux = widen(wen_q);
    if (hit(widx, IX_REN))   rd_mux = widen(ren_q);
    if (hit(widx, IX_FEN))   rd_mux = widen(fen_q);
    if (hit(widx, IX_FILT))  rd_mux = widen(filt_q);
    if (hit(widx, IX_PULL))  rd_mux = widen(pull_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      wake_o    <= 1'b0;
      nmi_o     <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq_o     <= |(pflag_q & ien_q);
      wake_o    <= (|(pflag_q & wen_q)) | nwake;
      nmi_o     <= nreq;
    end
  end

  assign pullup_en_o     = pull_q;
  assign filter_en_o     = filt_q;
  assign nmi_filter_en_o = ncfg.filt;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && hit(widx, IX_PFLAG)) |=> ((pflag_q & $past(pflag_q)) == $past(pflag_q))); // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(pflag_q & ien_q))); // R5
  AST_NMI_ROUTE: assert property (@(posedge clk) disable iff (rst)
    nmi_o |-> $past(nflag && ncfg.dss == 2'b00)); // R9
  AST_NSTAT_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(hit(widx, IX_NSTAT)) |-> (bus_rdata[29:0] == 30'd0)); // R7
endmodule

// File: tb/ext_wake_ctrl_tb_top.sv
module ext_wake_ctrl_tb_top;
  localparam int NPAD = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPAD-1:0] pad_in = '0;
  logic nmi_in = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_o, wake_o, nmi_o, nmi_filter_en_o;
  logic [NPAD-1:0] pullup_en_o, filter_en_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ext_wake_ctrl dut_i (
    .clk(clk), .rst(rst), .pad_in(pad_in), .nmi_in(nmi_in),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o), .nmi_o(nmi_o),
    .pullup_en_o(pullup_en_o), .filter_en_o(filter_en_o),
    .nmi_filter_en_o(nmi_filter_en_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic step_pad(input logic [NPAD-1:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step_nmi(input logic v);
    @(negedge clk);
    nmi_in = v;
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] edge_model(input logic [31:0] old, input logic [31:0] pv,
      input logic [31:0] nv, input logic [31:0] re, input logic [31:0] fe);
    return old | (nv & ~pv & re) | (~nv & pv & fe);
  endfunction

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      finish_up();
    end
  end

  initial begin
    logic [31:0] v, mflag, re, fe, ie, we, mask, nv;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 wake", {31'd0, wake_o}, 0);
    chk("R1 nmi", {31'd0, nmi_o}, 0);
    chk("R1 pull", pullup_en_o, 0);
    chk("R1 filt", filter_en_o, 0);
    for (int a = 0; a < 14; a++) begin
      rd(6'(a * 4), v);
      chk("R1 regs", v, 0);
    end

    // R2 readback and exported enables
    wr(6'h30, 32'hA5A5_0F0F);
    wr(6'h34, 32'h1234_8765);
    rd(6'h30, v); chk("R2 filt rd", v, 32'hA5A5_0F0F);
    rd(6'h34, v); chk("R2 pull rd", v, 32'h1234_8765);
    chk("R2 filt out", filter_en_o, 32'hA5A5_0F0F);
    chk("R2 pull out", pullup_en_o, 32'h1234_8765);
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h24, v); chk("R2 unmapped", v, 0);

    // R3 disabled edges set nothing
    step_pad(32'hFFFF_FFFF);
    step_pad(32'h0);
    rd(6'h14, v); chk("R3 disabled", v, 0);

    // random phase R3 R5 R6
    mflag = 0;
    re = 0; fe = 0; ie = 0; we = 0;
    for (int it = 0; it < 60; it++) begin
      if (it % 10 == 0) begin
        re = $urandom; fe = $urandom; ie = $urandom; we = $urandom;
        wr(6'h28, re); wr(6'h2C, fe); wr(6'h18, ie); wr(6'h1C, we);
        rd(6'h18, v); chk("R2 ien rd", v, ie);
        rd(6'h2C, v); chk("R2 fen rd", v, fe);
      end
      nv = $urandom;
      mflag = edge_model(mflag, pad_in, nv, re, fe);
      step_pad(nv);
      if ($urandom % 3 == 0) begin
        mask = $urandom;
        wr(6'h14, mask);
        mflag = mflag & ~mask;
      end
      rd(6'h14, v); chk("R3 flags", v, mflag);
      chk("R5 irq", {31'd0, irq_o}, {31'd0, |(mflag & ie)});
      chk("R6 wake", {31'd0, wake_o}, {31'd0, |(mflag & we)});
    end

    // R4 directed: write 0 no effect, set wins over clear
    wr(6'h28, 32'hFFFF_FFFF); wr(6'h2C, 32'hFFFF_FFFF);
    wr(6'h18, 32'h0000_0008); wr(6'h1C, 32'h0);
    wr(6'h14, 32'hFFFF_FFFF);
    rd(6'h14, v); chk("R4 clear all", v, 0);
    chk("R5 irq off", {31'd0, irq_o}, 0);
    step_pad(pad_in ^ 32'h8);
    rd(6'h14, v); chk("R3 single", v, 32'h8);
    chk("R5 irq on", {31'd0, irq_o}, 1);
    wr(6'h14, 32'h0);
    rd(6'h14, v); chk("R4 write0", v, 32'h8);
    @(negedge clk);
    pad_in = pad_in ^ 32'h8;
    @(posedge clk);
    @(posedge clk);
    wr(6'h14, 32'h8);
    rd(6'h14, v); chk("R4 set wins", v, 32'h8);
    repeat (4) @(posedge clk);
    wr(6'h14, 32'h8);
    rd(6'h14, v); chk("R4 w1c", v, 0);
    chk("R5 irq clear", {31'd0, irq_o}, 0);

    // NMI R7 R8 R9 R6
    wr(6'h08, 32'h3400_0000); // dss=01, rise en
    rd(6'h08, v); chk("R8 cfg", v, 32'h3400_0000);
    step_nmi(1'b1);
    rd(6'h00, v); chk("R7 flag", v, 32'h8000_0000);
    chk("R9 reserved dss", {31'd0, nmi_o}, 0);
    wr(6'h08, 32'h1400_0000); // dss=00, wake, rise
    rd(6'h00, v);
    chk("R9 nmi out", {31'd0, nmi_o}, 1);
    chk("R6 nmi wake", {31'd0, wake_o}, 1);
    step_nmi(1'b0);
    step_nmi(1'b1);
    rd(6'h00, v); chk("R7 overrun", v, 32'hC000_0000);
    wr(6'h00, 32'h8000_0000);
    rd(6'h00, v); chk("R7 ovf only", v, 32'h4000_0000);
    chk("R9 nmi off", {31'd0, nmi_o}, 0);
    chk("R6 ovf wake", {31'd0, wake_o}, 1);
    wr(6'h00, 32'h4000_0000);
    rd(6'h00, v); chk("R7 cleared", v, 0);
    chk("R6 wake off", {31'd0, wake_o}, 0);

    // R8 reserved bits and R10 lock
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, v); chk("R8 reserved", v, 32'hF700_0000);
    chk("R8 nmi filt", {31'd0, nmi_filter_en_o}, 1);
    wr(6'h08, 32'h0);
    rd(6'h08, v); chk("R10 locked", v, 32'hF700_0000);

    finish_up();
  end
endmodule